// File: doc/BRIEF.md
# Fractional Signed/Unsigned Multiplier with Product Scaler

This block multiplies two 16-bit operands and presents the result as a 40-bit value that can be added directly into a guard-bit accumulator. Each operand has its own signedness select. A signed operand is read as two's complement, and an unsigned operand is read as a plain magnitude. The exact 32-bit product is widened to 40 bits by sign extension when any operand is signed, and by zero extension when both are unsigned.

A fractional-mode input doubles the widened product, which is a left shift by one bit. This drops the redundant sign bit that a Q15 by Q15 multiply produces. No rounding or saturation is done here, so the corner case -1.0 x -1.0 produces +1.0 inside the guard bits.

The operands and controls are captured on a clock edge while `in_valid` is high. The result and `out_valid` appear one cycle later. The result register keeps its value until the next capture.

Top module: `mps_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_prod` is all zeros.
- R2: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was sampled high, and 0 in the cycle after one in which it was sampled low.
- R3: With `a_signed`=1, `b_signed`=1 and `frac_mode`=0, `out_prod` equals the two's complement product of the operands, in 40-bit two's complement.
- R4: With `a_signed`=0, `b_signed`=0 and `frac_mode`=0, `out_prod` equals the unsigned product, and bits 39:32 are zero.
- R5: With exactly one signedness select at 1, that operand is two's complement and the other is an unsigned magnitude, and `out_prod` is their product in 40-bit two's complement.
- R6: With `frac_mode`=1, `out_prod` equals twice the 40-bit value that R3, R4 or R5 give for the same operands, with bit 0 equal to 0.
- R7: Operands 8000h and 8000h, both signed, with `frac_mode`=1, give `out_prod` = 00_8000_0000h, with no saturation.
- R8: In a cycle where `in_valid` is low, the operand and control inputs are ignored, and `out_prod` keeps its previous value.
- R9: With `frac_mode`=0 and at least one operand signed, bits 39:31 of `out_prod` are all equal.
- R10: The exact product of the widened operands always fits in 33 signed bits. The two bits above the 32-bit product are equal, so truncating to 32 bits loses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for operands and controls |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: `op_a` is two's complement; 0: `op_a` is unsigned |
| b_signed | input | 1 | 1: `op_b` is two's complement; 0: `op_b` is unsigned |
| frac_mode | input | 1 | 1: double the widened product (Q15 alignment) |
| out_valid | output | 1 | Result in `out_prod` is new this cycle |
| out_prod | output | 40 | Registered, widened and scaled product |

## Verification
Two functions can fall in the same cycle, and the bench provokes both overlaps.

The first overlap is a capture landing in the same cycle that the previous result is presented. The bench provokes it by issuing captures back to back, with strobe gaps scattered among them. At each cycle it checks `out_valid` and `out_prod` against the operands issued one cycle before, or against the value held from the last capture.

The second overlap is the fractional shift acting on a product whose sign extension is live. The bench covers it by sweeping corner operands (zero, one, the most negative value, the largest magnitudes, mid-scale) under every signedness pair with both modes. It judges each result against an exact 64-bit integer product, doubled where fractional mode applies, and cut to 40 bits.

// File: rtl/mps_pkg.sv
package mps_pkg;

  parameter int unsigned MPS_OP_W  = 16;
  parameter int unsigned MPS_GUARD = 8;
  localparam int unsigned MPS_PROD_W = 2 * MPS_OP_W;
  localparam int unsigned MPS_OUT_W  = MPS_PROD_W + MPS_GUARD;

  typedef logic [MPS_PROD_W-1:0] mps_prod_t;
  typedef logic [MPS_OUT_W-1:0]  mps_out_t;

  // Widen the 32-bit product: replicate bit 31 when any operand was signed,
  // fill with zeros when both were unsigned.
  function automatic mps_out_t mps_widen(input mps_prod_t prod, input logic any_signed);
    logic fill;
    fill = any_signed & prod[MPS_PROD_W-1];
    return {{MPS_GUARD{fill}}, prod};
  endfunction

  // Fractional alignment: double the widened value, MSB falls off.
  function automatic mps_out_t mps_align(input mps_out_t wide, input logic frac);
    return frac ? {wide[MPS_OUT_W-2:0], 1'b0} : wide;
  endfunction

endpackage

// File: rtl/mps_operand_ext.sv
module mps_operand_ext #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]        op,
  input  logic                is_signed,
  output logic signed [W:0]   ext
);
  // One extra bit lets a single signed multiplier serve every mode.
  assign ext = $signed({is_signed & op[W-1], op});
endmodule

// File: rtl/mps_mul_core.sv
module mps_mul_core #(
  parameter int unsigned W = 16,
  localparam int unsigned FULL_W = 2 * (W + 1),
  localparam int unsigned PROD_W = 2 * W
) (
  input  logic signed [W:0]    a_ext,
  input  logic signed [W:0]    b_ext,
  output logic [PROD_W-1:0]    prod,
  output logic [1:0]           guard
);
  logic signed [FULL_W-1:0] full;

  assign full  = a_ext * b_ext;
  assign prod  = full[PROD_W-1:0];
  assign guard = full[FULL_W-1:PROD_W];
endmodule

// File: rtl/mps_scaler.sv
module mps_scaler
  import mps_pkg::*;
(
  input  mps_prod_t prod,
  input  logic      any_signed,
  input  logic      frac,
  output mps_out_t  scaled
);
  mps_out_t wide;

  assign wide   = mps_widen(prod, any_signed);
  assign scaled = mps_align(wide, frac);
endmodule

// File: rtl/mps_top.sv
module mps_top
  import mps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [MPS_OP_W-1:0]   op_a,
  input  logic [MPS_OP_W-1:0]   op_b,
  input  logic                  a_signed,
  input  logic                  b_signed,
  input  logic                  frac_mode,
  output logic                  out_valid,
  output logic [MPS_OUT_W-1:0]  out_prod
);
  localparam int unsigned N_OPS = 2;

  logic [MPS_OP_W-1:0]        op_arr  [N_OPS];
  logic                       sgn_arr [N_OPS];
  logic signed [MPS_OP_W:0]   ext_arr [N_OPS];

  // Named internal events for the checker.
  logic      cap_evt;
  logic      any_signed;
  logic [1:0] raw_guard;
  mps_prod_t raw_prod;
  mps_out_t  scaled_d;

  assign op_arr[0]  = op_a;
  assign op_arr[1]  = op_b;
  assign sgn_arr[0] = a_signed;
  assign sgn_arr[1] = b_signed;

  genvar gi;
  generate
    for (gi = 0; gi < N_OPS; gi++) begin : g_ext
      mps_operand_ext #(.W(MPS_OP_W)) u_ext (
        .op        (op_arr[gi]),
        .is_signed (sgn_arr[gi]),
        .ext       (ext_arr[gi])
      );
    end
  endgenerate

  assign cap_evt    = in_valid;
  assign any_signed = a_signed | b_signed;

  mps_mul_core #(.W(MPS_OP_W)) u_mul (
    .a_ext (ext_arr[0]),
    .b_ext (ext_arr[1]),
    .prod  (raw_prod),
    .guard (raw_guard)
  );

  mps_scaler u_scl (
    .prod       (raw_prod),
    .any_signed (any_signed),
    .frac       (frac_mode),
    .scaled     (scaled_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= cap_evt;
      if (cap_evt) out_prod <= scaled_d;
    end
  end

endmodule

// File: rtl/mps_top_chk.sv
module mps_top_chk
  import mps_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cap_evt,
  input logic                 a_signed,
  input logic                 b_signed,
  input logic                 frac_mode,
  input logic [1:0]           raw_guard,
  input logic                 out_valid,
  input logic [MPS_OUT_W-1:0] out_prod
);

  p_reset_r1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (!out_valid && out_prod == '0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> out_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> !out_valid);

  p_unsigned_guard_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !a_signed && !b_signed && !frac_mode) |=> (out_prod[MPS_OUT_W-1:MPS_PROD_W] == '0));

  p_frac_lsb_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && frac_mode) |=> (out_prod[0] == 1'b0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(out_prod));

  p_sign_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !frac_mode && (a_signed || b_signed)) |=>
      ((out_prod[MPS_OUT_W-1:MPS_PROD_W-1] == '0) || (&out_prod[MPS_OUT_W-1:MPS_PROD_W-1])));

  p_raw_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (raw_guard[1] == raw_guard[0]));

endmodule

bind mps_top mps_top_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_evt   (cap_evt),
  .a_signed  (a_signed),
  .b_signed  (b_signed),
  .frac_mode (frac_mode),
  .raw_guard (raw_guard),
  .out_valid (out_valid),
  .out_prod  (out_prod)
);

// File: tb/mps_top_tb_top.sv
module mps_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        a_signed, b_signed, frac_mode;
  logic        out_valid;
  logic [39:0] out_prod;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Expected state carried from the previous cycle.
  logic        prev_v = 1'b0;
  logic [39:0] prev_exp = '0;
  logic [39:0] held = '0;
  string       prev_tag = "R3";
  logic        prev_sgn_chk = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  mps_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
    .frac_mode(frac_mode), .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [39:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic sa, input logic sb, input logic fr);
    longint va, vb, p;
    va = sa ? longint'($signed(a)) : longint'(a);
    vb = sb ? longint'($signed(b)) : longint'(b);
    p  = va * vb;
    if (fr) p = p * 2;
    return p[39:0];
  endfunction

  function automatic logic [15:0] corner(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h8001;
      6: return 16'h4000;
      7: return 16'hC000;
      8: return 16'h00FF;
      default: return 16'h1234;
    endcase
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // At a negedge: judge the outputs produced by the previous drive, then drive anew.
  task automatic step(input logic [15:0] a, input logic [15:0] b,
                      input logic sa, input logic sb, input logic fr, input logic v);
    @(negedge clk);
    chk("R2", {39'd0, out_valid}, {39'd0, prev_v});
    if (prev_v) begin
      chk(prev_tag, out_prod, prev_exp);
      if (prev_sgn_chk)
        chk("R9", {31'd0, out_prod[39:31]},
            {31'd0, {9{prev_exp[31]}}});
      held = prev_exp;
    end else begin
      chk("R8", out_prod, held);
    end
    op_a = a; op_b = b; a_signed = sa; b_signed = sb; frac_mode = fr; in_valid = v;
    prev_v   = v;
    prev_exp = model(a, b, sa, sb, fr);
    prev_sgn_chk = !fr && (sa || sb);
    if (fr && sa && sb && a == 16'h8000 && b == 16'h8000) prev_tag = "R7";
    else if (fr)        prev_tag = "R6";
    else if (sa && sb)  prev_tag = "R3";
    else if (!sa && !sb) prev_tag = "R4";
    else                prev_tag = "R5";
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    a_signed = 1'b0; b_signed = 1'b0; frac_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {39'd0, out_valid}, 40'd0);
    chk("R1", out_prod, 40'd0);
    rst_n = 1'b1;

    // R7 explicit corner, with a literal expectation.
    step(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7", out_prod, 40'h00_8000_0000);
    in_valid = 1'b0; prev_v = 1'b0; held = 40'h00_8000_0000;

    // Corner sweep, back-to-back captures.
    for (int ia = 0; ia < 10; ia++)
      for (int ib = 0; ib < 10; ib++)
        for (int s = 0; s < 4; s++)
          for (int f = 0; f < 2; f++)
            step(corner(ia), corner(ib), s[1], s[0], f[0], 1'b1);

    // Scrambled operands with strobe gaps (R8: inputs ignored when idle).
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] ra, rb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rb = lfsr;
      step(ra, rb, ra[3], rb[5], ra[7] ^ rb[2], (ra[0] | rb[1]));
    end

    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule